// File: doc/BRIEF.md
# Sprite Line Scanner

The sprite line scanner runs once per scanline, during horizontal blanking, to prepare the sprite work for the line that follows. A one-cycle start strobe captures the current line number, the sprite height mode and the two base selections. The block then reads the table of sprite vertical positions from video memory, two entries per word. It keeps, in index order, every sprite whose rows cover the next line, up to a fixed list capacity.

When the vertical scan ends, the block walks the kept list. For each entry it reads the sprite's horizontal position and tile number, which share one memory word, and turns them into the video memory address of the tile row to draw. The results go into a draw list of fixed size that the pixel renderer reads through a select input. A sprite that was kept but finds no free draw slot raises an overflow flag. Memory arbitration and pixel output belong to neighbouring blocks.

Top module: `sprite_line_scan`

## Requirements
- R1: After reset `busy`, `done`, `mem_rd`, `sprite_ovf` are 0 and `draw_count` is 0.
- R2: The line under test is the captured `cur_line` plus one, modulo 256, so line 255 tests against line 0.
- R3: A sprite with vertical position Y is kept when Y <= L < Y + H, with the sum not wrapped, where L is the line under test and H is 16 when `tall_mode` is 1 and 8 otherwise.
- R4: At most LIST_DEPTH (16) sprites are kept per scan, the lowest indices first. The vertical scan stops after the word that fills the list, or after the last word of the table.
- R5: Each read of the vertical table returns two entries: even index in bits 7:0 and odd index in bits 15:8, at word address `attr_page`*128 + i/2. `mem_rd` is only high while `busy`. A scan makes one read per vertical word examined plus one per filled draw slot.
- R6: The word for sprite i is read at word address `attr_page`*128 + 64 + i, which is byte address base + 0x80 + 2i. Bits 7:0 hold the horizontal position and bits 15:8 hold the tile number. `rd_x` returns the position for draw slot `rd_sel`.
- R7: `rd_addr` for a slot equals (tile*32 + 0x2000*`tile_hi_sel` + (L - Y)*4) mod 0x4000.
- R8: `draw_count` = min(kept, DRAW_SLOTS) (DRAW_SLOTS = 8). Draw slots are filled in list order. `sprite_ovf` is 1 exactly when a kept sprite found no free draw slot.
- R9: A `scan_start` pulse in any state restarts the scan from index 0. In the next cycle `busy` is 1, `draw_count` is 0 and `sprite_ovf` is 0.
- R10: With the default STOP_ON_D0 = 0, the value 0xD0 is an ordinary vertical position. With STOP_ON_D0 = 1, 0xD0 ends the scan and that entry and all later ones are skipped.
- R11: When a scan completes, `done` goes to 1 with `busy` at 0. `done`, `draw_count`, `sprite_ovf` and the draw list then hold until the next `scan_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scan_start | input | 1 | One-cycle strobe that starts a line scan |
| cur_line | input | 8 | Current line number, captured at start |
| tall_mode | input | 1 | 1 = sprites 16 rows tall, 0 = 8 rows |
| attr_page | input | 6 | Attribute table base, byte address bits 13:8 |
| tile_hi_sel | input | 1 | Adds 0x2000 to every tile row address |
| mem_rd | output | 1 | Video memory word read request |
| mem_addr | output | 13 | Word address of the request |
| mem_data | input | 16 | Read data, valid the cycle after `mem_rd` |
| busy | output | 1 | Scan in progress |
| done | output | 1 | Scan complete, results stable |
| draw_count | output | 4 | Number of filled draw slots |
| rd_sel | input | 3 | Draw slot select |
| rd_x | output | 8 | Horizontal position of the selected slot |
| rd_addr | output | 14 | Tile row byte address of the selected slot |
| sprite_ovf | output | 1 | A kept sprite had no draw slot |

## Verification
The assertions check, on every cycle, the rules that do not depend on table contents. The draw count never exceeds its bound, and overflow only appears with every slot filled. Reads occur only while busy, and `done` and `busy` never overlap. A start strobe clears the results in the next cycle, and a finished result holds still. Only the bench's sweeps can show that the right sprites are kept for each line, height mode and table. Those sweeps also confirm the list cut-off at sixteen entries, the line wrap at 255, the edge positions near 0xD0 and 255, and the formed tile-row addresses and positions. The bench checks all of these against a model computed from the requirements.

// File: rtl/sps_pkg.sv
package sps_pkg;

    typedef enum logic [2:0] {
        SC_IDLE = 3'd0,
        SC_YREQ = 3'd1,
        SC_YCHK = 3'd2,
        SC_XREQ = 3'd3,
        SC_XCHK = 3'd4,
        SC_DONE = 3'd5
    } scan_st_e;

    // line under test: the one after the current line, wrapping at 256
    function automatic logic [7:0] next_line(input logic [7:0] cur);
        return cur + 8'd1;
    endfunction

endpackage

// File: rtl/sps_ymatch.sv
module sps_ymatch (
    input  logic [7:0] y_i,
    input  logic [7:0] line_i,
    input  logic       tall_i,
    output logic       hit_o,
    output logic [3:0] row_o
);
    logic [8:0] y_end;

    // nine-bit end so a sprite near 255 does not wrap onto low lines
    assign y_end = {1'b0, y_i} + (tall_i ? 9'd16 : 9'd8);
    assign hit_o = (line_i >= y_i) && ({1'b0, line_i} < y_end);
    assign row_o = line_i[3:0] - y_i[3:0];
endmodule

// File: rtl/sps_rowaddr.sv
module sps_rowaddr (
    input  logic [7:0]  tile_i,
    input  logic [3:0]  row_i,
    input  logic        hi_i,
    output logic [13:0] addr_o
);
    // 32 bytes per tile, 4 bytes per pixel row, optional upper half
    assign addr_o = {hi_i, 13'd0} + {1'b0, tile_i, 5'd0} + {8'd0, row_i, 2'd0};
endmodule

// File: rtl/sprite_line_scan.sv
module sprite_line_scan #(
    parameter int NUM_SPRITES = 64,
    parameter int LIST_DEPTH  = 16,
    parameter int DRAW_SLOTS  = 8,
    parameter bit STOP_ON_D0  = 1'b0,
    localparam int DSEL_W = $clog2(DRAW_SLOTS),
    localparam int DCNT_W = DSEL_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scan_start,
    input  logic [7:0]        cur_line,
    input  logic              tall_mode,
    input  logic [5:0]        attr_page,
    input  logic              tile_hi_sel,
    output logic              mem_rd,
    output logic [12:0]       mem_addr,
    input  logic [15:0]       mem_data,
    output logic              busy,
    output logic              done,
    output logic [DCNT_W-1:0] draw_count,
    input  logic [DSEL_W-1:0] rd_sel,
    output logic [7:0]        rd_x,
    output logic [13:0]       rd_addr,
    output logic              sprite_ovf
);
    import sps_pkg::*;

    localparam int IDX_W  = $clog2(NUM_SPRITES);
    localparam int PAIR_W = IDX_W - 1;
    localparam int LSEL_W = $clog2(LIST_DEPTH);
    localparam int LCNT_W = LSEL_W + 1;
    localparam logic [PAIR_W-1:0] LAST_PAIR = PAIR_W'(NUM_SPRITES / 2 - 1);
    localparam logic [LCNT_W-1:0] LIST_FULL = LCNT_W'(LIST_DEPTH);
    localparam logic [DCNT_W-1:0] DRAW_FULL = DCNT_W'(DRAW_SLOTS);
    localparam logic [12:0]       XT_OFS    = 13'h0040;

    typedef struct packed {
        scan_st_e                              st;
        logic [7:0]                            ln;
        logic                                  tall;
        logic [5:0]                            page;
        logic                                  hsel;
        logic [PAIR_W-1:0]                     pair;
        logic [LCNT_W-1:0]                     lcnt;
        logic [LSEL_W-1:0]                     fj;
        logic [LIST_DEPTH-1:0][IDX_W-1:0]      lidx;
        logic [LIST_DEPTH-1:0][3:0]            lrow;
        logic [DCNT_W-1:0]                     dcnt;
        logic [DRAW_SLOTS-1:0][7:0]            dx;
        logic [DRAW_SLOTS-1:0][13:0]           da;
        logic                                  ovf;
    } scan_s;

    scan_s q, d;

    // two lanes: even entry in the low byte, odd entry in the high byte
    logic [1:0]       lane_hit;
    logic [1:0]       lane_stop;
    logic [1:0][3:0]  lane_row;

    for (genvar g = 0; g < 2; g++) begin : g_lane
        sps_ymatch u_match (
            .y_i    (mem_data[8*g +: 8]),
            .line_i (q.ln),
            .tall_i (q.tall),
            .hit_o  (lane_hit[g]),
            .row_o  (lane_row[g])
        );
        if (STOP_ON_D0) begin : g_stop
            assign lane_stop[g] = (mem_data[8*g +: 8] == 8'hD0);
        end else begin : g_nostop
            assign lane_stop[g] = 1'b0;
        end
    end

    logic              acc0, acc1, scan_end;
    logic [LCNT_W-1:0] cnt0, cnt1;

    assign acc0     = lane_hit[0] && !lane_stop[0];
    assign cnt0     = q.lcnt + LCNT_W'(acc0);
    assign acc1     = lane_hit[1] && !lane_stop[0] && !lane_stop[1] && (cnt0 != LIST_FULL);
    assign cnt1     = cnt0 + LCNT_W'(acc1);
    assign scan_end = lane_stop[0] || lane_stop[1] || (cnt1 == LIST_FULL) || (q.pair == LAST_PAIR);

    logic [13:0] row_addr;

    sps_rowaddr u_rowaddr (
        .tile_i (mem_data[15:8]),
        .row_i  (q.lrow[q.fj]),
        .hi_i   (q.hsel),
        .addr_o (row_addr)
    );

    logic [12:0] page_w;
    assign page_w = {q.page, 7'd0};

    always_comb begin
        d = q;
        unique case (q.st)
            SC_YREQ: d.st = SC_YCHK;
            SC_YCHK: begin
                if (acc0) begin
                    d.lidx[q.lcnt[LSEL_W-1:0]] = {q.pair, 1'b0};
                    d.lrow[q.lcnt[LSEL_W-1:0]] = lane_row[0];
                end
                if (acc1) begin
                    d.lidx[cnt0[LSEL_W-1:0]] = {q.pair, 1'b1};
                    d.lrow[cnt0[LSEL_W-1:0]] = lane_row[1];
                end
                d.lcnt = cnt1;
                if (scan_end) begin
                    d.fj = '0;
                    d.st = (cnt1 == '0) ? SC_DONE : SC_XREQ;
                end else begin
                    d.pair = q.pair + 1'b1;
                    d.st   = SC_YREQ;
                end
            end
            SC_XREQ: begin
                if (q.dcnt == DRAW_FULL) begin
                    d.ovf = 1'b1;
                    d.st  = SC_DONE;
                end else begin
                    d.st = SC_XCHK;
                end
            end
            SC_XCHK: begin
                d.dx[q.dcnt[DSEL_W-1:0]] = mem_data[7:0];
                d.da[q.dcnt[DSEL_W-1:0]] = row_addr;
                d.dcnt = q.dcnt + 1'b1;
                if (({1'b0, q.fj} + 1'b1) == q.lcnt) begin
                    d.st = SC_DONE;
                end else begin
                    d.fj = q.fj + 1'b1;
                    d.st = SC_XREQ;
                end
            end
            default: ;
        endcase

        if (scan_start) begin
            d.st   = SC_YREQ;
            d.ln   = next_line(cur_line);
            d.tall = tall_mode;
            d.page = attr_page;
            d.hsel = tile_hi_sel;
            d.pair = '0;
            d.lcnt = '0;
            d.fj   = '0;
            d.dcnt = '0;
            d.ovf  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        if (q.st == SC_YREQ) begin
            mem_addr = page_w + 13'(q.pair);
        end else begin
            mem_addr = page_w + XT_OFS + 13'(q.lidx[q.fj]);
        end
    end

    assign mem_rd     = (q.st == SC_YREQ) || ((q.st == SC_XREQ) && (q.dcnt != DRAW_FULL));
    assign busy       = (q.st == SC_YREQ) || (q.st == SC_YCHK) || (q.st == SC_XREQ) || (q.st == SC_XCHK);
    assign done       = (q.st == SC_DONE);
    assign draw_count = q.dcnt;
    assign sprite_ovf = q.ovf;
    assign rd_x       = q.dx[rd_sel];
    assign rd_addr    = q.da[rd_sel];

endmodule

// File: rtl/sprite_line_scan_chk.sv
module sprite_line_scan_chk #(
    parameter int DRAW_SLOTS = 8,
    parameter int DCNT_W     = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scan_start,
    input logic              busy,
    input logic              done,
    input logic              mem_rd,
    input logic [DCNT_W-1:0] draw_count,
    input logic              sprite_ovf
);
    localparam logic [DCNT_W-1:0] FULL = DCNT_W'(DRAW_SLOTS);

    assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        draw_count <= FULL);

    assert_ovf_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sprite_ovf |-> (draw_count == FULL));

    assert_rd_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> busy);

    assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && busy));

    assert_start_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        scan_start |=> (busy && (draw_count == '0) && !sprite_ovf));

    assert_done_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !scan_start) |=> (done && $stable(draw_count) && $stable(sprite_ovf)));
endmodule

bind sprite_line_scan sprite_line_scan_chk #(
    .DRAW_SLOTS (DRAW_SLOTS),
    .DCNT_W     (DCNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scan_start (scan_start),
    .busy       (busy),
    .done       (done),
    .mem_rd     (mem_rd),
    .draw_count (draw_count),
    .sprite_ovf (sprite_ovf)
);

// File: tb/sprite_line_scan_test.sv
`timescale 1ns/1ps
module sprite_line_scan_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scan_start = 1'b0;
    logic [7:0]  cur_line = '0;
    logic        tall_mode = 1'b0;
    logic [5:0]  attr_page = '0;
    logic        tile_hi_sel = 1'b0;
    logic        mem_rd;
    logic [12:0] mem_addr;
    logic [15:0] mem_data = '0;
    logic        busy, done, sprite_ovf;
    logic [3:0]  draw_count;
    logic [2:0]  rd_sel = '0;
    logic [7:0]  rd_x;
    logic [13:0] rd_addr;

    sprite_line_scan uut (
        .clk(clk), .rst_n(rst_n), .scan_start(scan_start), .cur_line(cur_line),
        .tall_mode(tall_mode), .attr_page(attr_page), .tile_hi_sel(tile_hi_sel),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_data(mem_data),
        .busy(busy), .done(done), .draw_count(draw_count), .rd_sel(rd_sel),
        .rd_x(rd_x), .rd_addr(rd_addr), .sprite_ovf(sprite_ovf)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    int rd_total = 0;
    int ytab [64];
    int xtab [64];
    int ttab [64];
    int e_d, e_ovf, e_reads;
    int e_x [8];
    int e_a [8];

    function automatic int mdl(int wa);
        int bw = int'(attr_page) * 128;
        if (wa >= bw && wa < bw + 32) return ytab[2*(wa-bw)+1] * 256 + ytab[2*(wa-bw)];
        if (wa >= bw + 64 && wa < bw + 128) return ttab[wa-bw-64] * 256 + xtab[wa-bw-64];
        return (wa * 40503 + 7) & 16'hFFFF;
    endfunction

    always @(posedge clk) begin
        if (mem_rd) begin
            mem_data <= 16'(mdl(int'(mem_addr)));
            rd_total <= rd_total + 1;
        end
    end

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    // reference computed from the requirement text
    task automatic model(int line, bit tall);
        int l = (line + 1) % 256;
        int h = tall ? 16 : 8;
        int cnt = 0;
        int pairs = 0;
        int kidx [16];
        int krow [16];
        for (int p = 0; p < 32; p++) begin
            pairs++;
            for (int ln = 0; ln < 2; ln++) begin
                int i = 2*p + ln;
                if (cnt < 16 && ytab[i] <= l && l < ytab[i] + h) begin
                    kidx[cnt] = i;
                    krow[cnt] = l - ytab[i];
                    cnt++;
                end
            end
            if (cnt == 16) break;
        end
        e_d = (cnt < 8) ? cnt : 8;
        e_ovf = (cnt > 8) ? 1 : 0;
        e_reads = pairs + e_d;
        for (int j = 0; j < e_d; j++) begin
            e_x[j] = xtab[kidx[j]];
            e_a[j] = (ttab[kidx[j]] * 32 + (tile_hi_sel ? 8192 : 0) + krow[j] * 4) % 16384;
        end
    endtask

    task automatic scan(int line, bit tall, string ctag, bit chk_reads);
        int base;
        @(negedge clk);
        cur_line = 8'(line);
        tall_mode = tall;
        scan_start = 1'b1;
        base = rd_total;
        @(negedge clk);
        scan_start = 1'b0;
        for (int k = 0; k < 400 && !done; k++) @(negedge clk);
        model(line, tall);
        chk({ctag, " count"}, int'(draw_count), e_d);
        chk("R8 ovf", int'(sprite_ovf), e_ovf);
        if (chk_reads) chk("R5 reads", rd_total - base, e_reads);
        for (int j = 0; j < e_d; j++) begin
            rd_sel = 3'(j);
            #0.5;
            chk("R6 x", int'(rd_x), e_x[j]);
            chk("R7 addr", int'(rd_addr), e_a[j]);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog act=0 exp=1");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 busy", int'(busy), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 rd", int'(mem_rd), 0);
        chk("R1 ovf", int'(sprite_ovf), 0);
        chk("R1 count", int'(draw_count), 0);
        rst_n = 1'b1;

        // table A: spread positions, full line sweep, both heights (R3)
        for (int i = 0; i < 64; i++) begin
            ytab[i] = (i * 37 + 11) % 256;
            xtab[i] = (i * 7 + 3) % 256;
            ttab[i] = (i * 13 + 5) % 256;
        end
        attr_page = 6'h3F;
        tile_hi_sel = 1'b1;
        for (int t = 0; t < 2; t++)
            for (int ln = 0; ln < 256; ln++)
                scan(ln, t[0], (ln == 255) ? "R2" : "R3", 1'b1);

        // R11: result holds while idle
        scan(10, 1'b1, "R3", 1'b1);
        repeat (10) @(negedge clk);
        chk("R11 done", int'(done), 1);
        chk("R11 busy", int'(busy), 0);
        chk("R11 count", int'(draw_count), e_d);

        // table B: clustered, list fills and draw slots overflow (R4)
        for (int i = 0; i < 64; i++) begin
            ytab[i] = 100 + (i % 3);
            xtab[i] = (i * 11 + 1) % 256;
            ttab[i] = 255 - i;
        end
        attr_page = 6'h08;
        tile_hi_sel = 1'b0;
        for (int t = 0; t < 2; t++)
            for (int ln = 90; ln < 121; ln++)
                scan(ln, t[0], "R4", 1'b1);

        // R9: restart in the middle of an overflowing scan
        @(negedge clk);
        cur_line = 8'd101;
        tall_mode = 1'b0;
        scan_start = 1'b1;
        @(negedge clk);
        scan_start = 1'b0;
        repeat (5) @(negedge clk);
        scan(95, 1'b0, "R9", 1'b0);
        scan(101, 1'b1, "R9", 1'b0);

        // table C: edges near 0xD0 and the top of the range (R10, R2)
        for (int i = 0; i < 64; i++) begin
            ytab[i] = 40;
            xtab[i] = (i * 5 + 9) % 256;
            ttab[i] = (i * 29 + 200) % 256;
        end
        ytab[0] = 8'hD0;
        ytab[1] = 250;
        ytab[2] = 255;
        ytab[3] = 0;
        ytab[4] = 248;
        ytab[9] = 8'hD0;
        attr_page = 6'h15;
        tile_hi_sel = 1'b1;
        for (int t = 0; t < 2; t++) begin
            scan(8'hCF, t[0], "R10", 1'b1);
            scan(8'hD0, t[0], "R10", 1'b1);
            for (int ln = 247; ln < 256; ln++) scan(ln, t[0], "R2", 1'b1);
            for (int ln = 0; ln < 4; ln++) scan(ln, t[0], "R3", 1'b1);
        end

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule